// File: doc/BRIEF.md
# Spread-Duty Pulse Generator

The block turns an N-bit duty value into a one-bit output whose high time per period equals that value. A free-running counter of N bits defines a period of 2^N clocks. In the default spread mode the counter bits are mirrored (most significant bit swapped with least significant bit, and so on) before being compared with the duty value, so the high clocks are spread evenly across the period instead of being bunched into one pulse. A plain mode compares the unmirrored count and gives a conventional single pulse with the same high count, for comparison or for loads that prefer one edge pair per period.

The duty value and the mode are written through a plain write strobe into a pending register. They reach the comparator only at a period boundary, so a period in progress is never cut short or stretched. While the block is disabled, writes reach the comparator directly and the counter stays at zero, so the first period after enabling already uses them. The duty and mode pins are plain control inputs with no handshake: a write is taken on every clock in which the strobe is high.

Top module: `dpm_gen`

## Requirements
- R1: While enable is high the counter advances by one each clock and wraps after 2^W clocks (W = 3 by default, period 8). While enable is low it is held at zero.
- R2: In spread mode (plain_mode = 0) the compare value is the count with bit i moved to bit W-1-i. The output is high while the compare value is below the active duty. For W = 3 the slots 0..7 use compare values 0,4,2,6,1,5,3,7, so duty 4 gives the pattern 1,0,1,0,1,0,1,0.
- R3: In plain mode (plain_mode = 1) the count is compared unchanged, so duty B makes slots 0..B-1 high and the rest low.
- R4: In either mode, duty B gives exactly B high clocks in every period.
- R5: Duty 0 keeps the output low on every clock. Duty 2^W-1 makes the output low on exactly one clock per period: slot 2^W-1 in both modes.
- R6: A duty or mode write while enabled does not change the period in progress. It applies from slot 0 of the next period, and the last write before the boundary wins. A write in the final slot still counts for the next period.
- R7: When enable is low the output is low in that same cycle. A write made while disabled becomes active at the next clock edge, so the first period after enable rises uses it.
- R8: During and right after reset the output is low, the duty is 0, the mode is spread and the counter is 0, even if enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counter; low forces the output low |
| duty_wr | input | 1 | Write strobe for duty_in and plain_mode |
| duty_in | input | W | New duty value (high clocks per period) |
| plain_mode | input | 1 | 1 = plain single pulse, 0 = spread pattern |
| pulse_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running period, with the duty and the mode both changing, followed by a boundary where the old period must finish unchanged and the new one must start at slot 0. The bench enables the block with a known duty, counts clocks from the enable edge to locate each slot, and issues the write in slot 3. It then checks every slot of that period and of the next one against patterns worked out from the mirror rule. A similar sequence drops enable in mid-period and checks that the counter restarts at slot 0 by using duty 1, which is high only in slot 0.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  parameter int unsigned DEF_W = 3;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_PLAIN  = 1'b1
  } dpm_mode_e;
endpackage

// File: rtl/dpm_counter.sv
module dpm_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  output logic [W-1:0] count,
  output logic         last_slot
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (enable) count <= count + 1'b1;
    else             count <= '0;
  end

  assign last_slot = (count == MAXC);

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (count == W'($past(count) + 1'b1))); // R1
endmodule

// File: rtl/dpm_shadow.sv
module dpm_shadow #(
  parameter int unsigned W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            last_slot,
  input  logic            duty_wr,
  input  logic [W-1:0]    duty_in,
  input  logic            plain_mode,
  output logic [W-1:0]    duty_act,
  output dpm_pkg::dpm_mode_e mode_act
);
  import dpm_pkg::*;

  logic [W-1:0] pend_q, pend_nxt;
  dpm_mode_e    mpend_q, mpend_nxt;
  logic         load;

  always_comb begin
    pend_nxt  = duty_wr ? duty_in : pend_q;
    mpend_nxt = duty_wr ? dpm_mode_e'(plain_mode) : mpend_q;
    load      = !enable || last_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mpend_q  <= MODE_SPREAD;
      duty_act <= '0;
      mode_act <= MODE_SPREAD;
    end else begin
      pend_q  <= pend_nxt;
      mpend_q <= mpend_nxt;
      if (load) begin
        duty_act <= pend_nxt;
        mode_act <= mpend_nxt;
      end
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !last_slot) |=> ($stable(duty_act) && $stable(mode_act))); // R6
  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && duty_wr) |=> (duty_act == $past(duty_in))); // R7
endmodule

// File: rtl/dpm_compare.sv
module dpm_compare #(
  parameter int unsigned W = 3
) (
  input  logic               enable,
  input  logic [W-1:0]       count,
  input  logic [W-1:0]       duty_act,
  input  dpm_pkg::dpm_mode_e mode_act,
  output logic               hit
);
  import dpm_pkg::*;

  logic [W-1:0] mirrored;
  logic [W-1:0] cmp_val;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirrored[i] = count[W-1-i];
  end

  always_comb begin
    cmp_val = (mode_act == MODE_PLAIN) ? count : mirrored;
    hit     = enable && (cmp_val < duty_act);
  end

  always_comb begin
    AST_ZERO_DUTY: assert (duty_act != '0 || !hit); // R5
  end
endmodule

// File: rtl/dpm_gen.sv
module dpm_gen #(
  parameter int unsigned W = dpm_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_in,
  input  logic         plain_mode,
  output logic         pulse_out
);
  import dpm_pkg::*;

  logic [W-1:0] count;
  logic         last_slot;
  logic [W-1:0] duty_act;
  dpm_mode_e    mode_act;
  logic [W:0]   highs_q;

  dpm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .count(count), .last_slot(last_slot)
  );

  dpm_shadow #(.W(W)) u_shd (
    .clk(clk), .rst_n(rst_n), .enable(enable), .last_slot(last_slot),
    .duty_wr(duty_wr), .duty_in(duty_in), .plain_mode(plain_mode),
    .duty_act(duty_act), .mode_act(mode_act)
  );

  dpm_compare #(.W(W)) u_cmp (
    .enable(enable), .count(count), .duty_act(duty_act),
    .mode_act(mode_act), .hit(pulse_out)
  );

  // running count of high slots in the current period, for the check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   highs_q <= '0;
    else if (!enable || last_slot) highs_q <= '0;
    else                          highs_q <= highs_q + {{W{1'b0}}, pulse_out};
  end

  AST_DUTY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && last_slot) |-> ((highs_q + {{W{1'b0}}, pulse_out}) == {1'b0, duty_act})); // R4
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pulse_out); // R7
endmodule

// File: tb/dpm_gen_test.sv
module dpm_gen_test;
  localparam int W = 3;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         duty_wr = 1'b0;
  logic [W-1:0] duty_in = '0;
  logic         plain_mode = 1'b0;
  logic         pulse_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dpm_gen #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .duty_wr(duty_wr),
    .duty_in(duty_in), .plain_mode(plain_mode), .pulse_out(pulse_out)
  );

  function automatic int mirror(input int k);
    int r = 0;
    for (int i = 0; i < W; i++) if (k[i]) r |= (1 << (W-1-i));
    return r;
  endfunction

  function automatic logic expect_bit(input int slot, input int duty, input bit plain);
    int c = plain ? slot : mirror(slot);
    return (c < duty);
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // disabled write: goes straight to the active register
  task automatic idle_set(input int duty, input bit plain);
    @(negedge clk);
    enable = 1'b0; duty_wr = 1'b1; duty_in = W'(duty); plain_mode = plain;
    @(negedge clk);
    duty_wr = 1'b0;
  endtask

  // called right after the negedge at which enable rose or a period began
  task automatic run_period(input int duty, input bit plain, input string tag);
    int n = 0;
    for (int k = 0; k < P; k++) begin
      #1;
      check(pulse_out, expect_bit(k, duty, plain), $sformatf("%s slot %0d", tag, k));
      n += pulse_out;
      @(negedge clk);
    end
    check_int(n, duty, {tag, " R4 high count"});
  endtask

  task automatic t_reset();
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(pulse_out, 1'b0, "R8 output low in reset");
    rst_n = 1'b1;
    #1 check(pulse_out, 1'b0, "R8 duty zero after reset");
    @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic t_spread();
    int duties[4] = '{4, 1, 3, 6};
    foreach (duties[j]) begin
      idle_set(duties[j], 1'b0);
      enable = 1'b1;
      run_period(duties[j], 1'b0, $sformatf("R2 spread duty %0d", duties[j]));
      run_period(duties[j], 1'b0, $sformatf("R1 second period duty %0d", duties[j]));
    end
  endtask

  task automatic t_plain();
    idle_set(3, 1'b1);
    enable = 1'b1;
    run_period(3, 1'b1, "R3 plain duty 3");
    idle_set(5, 1'b1);
    enable = 1'b1;
    run_period(5, 1'b1, "R3 plain duty 5");
  endtask

  task automatic t_limits();
    idle_set(0, 1'b0);
    enable = 1'b1;
    run_period(0, 1'b0, "R5 duty zero spread");
    idle_set(P-1, 1'b0);
    enable = 1'b1;
    run_period(P-1, 1'b0, "R5 duty max spread");
    idle_set(P-1, 1'b1);
    enable = 1'b1;
    run_period(P-1, 1'b1, "R5 duty max plain");
  endtask

  task automatic t_shadow();
    int n = 0;
    idle_set(2, 1'b0);
    enable = 1'b1;
    for (int k = 0; k < P; k++) begin
      #1;
      check(pulse_out, expect_bit(k, 2, 1'b0), $sformatf("R6 old period slot %0d", k));
      n += pulse_out;
      if (k == 3) begin duty_wr = 1'b1; duty_in = W'(1); plain_mode = 1'b0; end
      if (k == 4) begin duty_wr = 1'b1; duty_in = W'(6); plain_mode = 1'b1; end
      if (k == 5) duty_wr = 1'b0;
      if (k == 7) begin duty_wr = 1'b1; duty_in = W'(5); plain_mode = 1'b1; end
      @(negedge clk);
    end
    duty_wr = 1'b0;
    check_int(n, 2, "R6 old period count");
    run_period(5, 1'b1, "R6 new period last write");
  endtask

  task automatic t_disable();
    idle_set(5, 1'b0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1 check(pulse_out, 1'b0, "R7 low same cycle");
    @(negedge clk);
    duty_wr = 1'b1; duty_in = W'(1); plain_mode = 1'b0;
    #1 check(pulse_out, 1'b0, "R7 low while off");
    @(negedge clk);
    duty_wr = 1'b0;
    enable = 1'b1;
    run_period(1, 1'b0, "R7 R1 restart at slot 0");
    enable = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_spread();
    t_plain();
    t_limits();
    t_shadow();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule